// File: doc/BRIEF.md
# Conditional Execute and Repeat Sequencer

This block sits between an instruction decoder and the execution units and decides, for each decoded instruction, whether the instruction runs and how often. When a start strobe arrives it captures a five-bit condition field and a repeat flag. It then tests the condition against the live status flags (carry, overflow, zero, sign, parity) and against the count register. If the test passes, it issues a one-cycle execute-enable pulse. If the test fails, it finishes without executing.

With the repeat flag set, every execution is followed by a one-cycle decrement strobe for the count register, which lives outside this block. The block then re-tests before the next iteration. Repetition stops when the count reaches zero or when the condition becomes false. The flags are read again in every test cycle, so an instruction that changes the flags steers its own loop. A reserved condition code ends the sequence with an illegal-condition indication. The done output marks the end of every sequence.

Top module: `cond_rep_seq`

## Requirements
- R1: After synchronous reset, exec_o, dec_o, done_o and illegal_o are all low, and the block waits for start_i.
- R2: cond_i[3:0] is the condition code and cond_i[4] the invert bit. Code 0 always passes. Codes 1, 2, 3, 4 and 5 pass when carry, overflow, zero, sign and parity are set, respectively. The flag positions are flags_i[0] carry, [1] overflow, [2] zero, [3] sign, [4] parity.
- R3: The unsigned codes are tested as follows. Code 6 passes when carry and zero are both clear. Code 7 passes when carry is clear. Code 8 passes when carry is set. Code 9 passes when carry or zero is set.
- R4: The signed codes are tested as follows. Code 10 passes when zero is clear and sign equals overflow. Code 11 passes when sign equals overflow. Code 12 passes when sign differs from overflow. Code 13 passes when zero is set or sign differs from overflow.
- R5: Code 14 passes when count_i is zero.
- R6: cond_i[4] = 1 inverts the outcome of codes 0 to 14.
- R7: Code 15, with either invert value, produces no execute pulse. It ends the sequence with illegal_o high in the same single cycle as done_o. Code 15 is reported even when the count is zero.
- R8: Without repeat, a passing test gives exactly one exec_o pulse, two cycles after start_i is sampled, with done_o one cycle later. A failing test gives done_o two cycles after start and no execute pulse. dec_o never rises.
- R9: With repeat, each exec_o pulse is followed in the next cycle by one dec_o pulse, and iterations are three cycles apart. With a condition that always passes, a starting count of N gives N executions and N decrements.
- R10: With repeat and a count of zero at the test, the sequence ends without executing, and done_o follows in the next cycle.
- R11: The condition is re-tested with fresh flags before every iteration. A failing test ends the sequence with no further execute pulse and no decrement.
- R12: exec_o, dec_o and done_o are each single-cycle pulses, and they are never high together.
- R13: start_i is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one decoded instruction |
| cond_i | input | 5 | Condition field: invert bit [4], code [3:0] |
| rep_i | input | 1 | Repeat request |
| flags_i | input | 5 | Status flags: parity, sign, zero, overflow, carry (bit 4 down to 0) |
| count_i | input | CNT_W | Current count register value |
| exec_o | output | 1 | Execute enable, one cycle per iteration |
| dec_o | output | 1 | Count register decrement strobe |
| done_o | output | 1 | Sequence finished |
| illegal_o | output | 1 | Reserved condition code seen; high together with done_o |

## Verification
The bench builds the block with CNT_W = 8. An 8-bit count lets a repeat run of 200 iterations, close to the top of the count range, finish in a few hundred cycles, so the loop is exercised well past short counts. That width also keeps every code-by-flag-pattern case cheap enough to sweep in full, both plain and inverted. The bench plays the role of the count register and of an instruction that rewrites the zero flag partway through a loop, which brings the per-iteration re-test into reach.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef struct packed {
        logic pf;
        logic sf;
        logic zf;
        logic of;
        logic cf;
    } flags_t;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_CARRY  = 4'd1,
        CC_OVF    = 4'd2,
        CC_ZERO   = 4'd3,
        CC_SIGN   = 4'd4,
        CC_PAR    = 4'd5,
        CC_ABOVE  = 4'd6,
        CC_AEQ    = 4'd7,
        CC_BELOW  = 4'd8,
        CC_BEQ    = 4'd9,
        CC_GT     = 4'd10,
        CC_GE     = 4'd11,
        CC_LT     = 4'd12,
        CC_LE     = 4'd13,
        CC_CNTZ   = 4'd14,
        CC_RSVD   = 4'd15
    } cc_e;

    typedef struct packed {
        logic inv;
        cc_e  code;
    } cond_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_EXEC,
        ST_DEC,
        ST_DONE
    } seq_state_e;

    function automatic logic cc_test(cc_e c, flags_t f, logic cnt_zero);
        logic r;
        unique case (c)
            CC_ALWAYS: r = 1'b1;
            CC_CARRY:  r = f.cf;
            CC_OVF:    r = f.of;
            CC_ZERO:   r = f.zf;
            CC_SIGN:   r = f.sf;
            CC_PAR:    r = f.pf;
            CC_ABOVE:  r = !(f.cf || f.zf);
            CC_AEQ:    r = !f.cf;
            CC_BELOW:  r = f.cf;
            CC_BEQ:    r = f.cf || f.zf;
            CC_GT:     r = !f.zf && (f.sf == f.of);
            CC_GE:     r = (f.sf == f.of);
            CC_LT:     r = (f.sf != f.of);
            CC_LE:     r = f.zf || (f.sf != f.of);
            CC_CNTZ:   r = cnt_zero;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cseq_cond_eval.sv
module cseq_cond_eval
    import cseq_pkg::*;
(
    input  cond_t  cond_i,
    input  flags_t flags_i,
    input  logic   cnt_zero_i,
    output logic   pass_o,
    output logic   illegal_o
);

    always_comb begin
        illegal_o = (cond_i.code == CC_RSVD);
        pass_o    = !illegal_o && (cond_i.inv ^ cc_test(cond_i.code, flags_i, cnt_zero_i));
    end

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
    import cseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic rep_i,
    input  logic pass_i,
    input  logic illegal_i,
    input  logic cnt_zero_i,
    output logic accept_o,
    output logic exec_o,
    output logic dec_o,
    output logic done_o,
    output logic illegal_o
);

    seq_state_e state_q;
    logic       rep_q;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rep_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rep_q   <= rep_i;
                        err_q   <= 1'b0;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (illegal_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (rep_q && cnt_zero_i) begin
                        state_q <= ST_DONE;
                    end else if (pass_i) begin
                        state_q <= ST_EXEC;
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                ST_EXEC: state_q <= rep_q ? ST_DEC : ST_DONE;
                ST_DEC:  state_q <= ST_EVAL;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept_o  = (state_q == ST_IDLE) && start_i;
        exec_o    = (state_q == ST_EXEC);
        dec_o     = (state_q == ST_DEC);
        done_o    = (state_q == ST_DONE);
        illegal_o = (state_q == ST_DONE) && err_q;
    end

    a_r12_exec_single: assert property (@(posedge clk) disable iff (rst)
        exec_o |=> !exec_o);

    a_r12_outputs_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exec_o, dec_o, done_o}));

    a_r9_dec_follows_exec: assert property (@(posedge clk) disable iff (rst)
        dec_o |-> $past(exec_o));

    a_r8_dec_only_on_repeat: assert property (@(posedge clk) disable iff (rst)
        dec_o |-> rep_q);

    a_r7_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> done_o);

    a_r11_fail_no_exec: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL && !pass_i) |=> (!exec_o && done_o));

    a_r10_zero_count_ends: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL && rep_q && cnt_zero_i) |=> (done_o && !exec_o));

endmodule

// File: rtl/cond_rep_seq.sv
module cond_rep_seq
    import cseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [4:0]       cond_i,
    input  logic             rep_i,
    input  logic [4:0]       flags_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             exec_o,
    output logic             dec_o,
    output logic             done_o,
    output logic             illegal_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    cond_t  cond_q;
    flags_t flags;
    logic   cnt_zero;
    logic   accept;
    logic   pass;
    logic   bad_code;

    assign flags    = flags_t'(flags_i);
    assign cnt_zero = (count_i == CNT_ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
        end else if (accept) begin
            cond_q <= cond_t'(cond_i);
        end
    end

    cseq_cond_eval u_eval (
        .cond_i     (cond_q),
        .flags_i    (flags),
        .cnt_zero_i (cnt_zero),
        .pass_o     (pass),
        .illegal_o  (bad_code)
    );

    cseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rep_i      (rep_i),
        .pass_i     (pass),
        .illegal_i  (bad_code),
        .cnt_zero_i (cnt_zero),
        .accept_o   (accept),
        .exec_o     (exec_o),
        .dec_o      (dec_o),
        .done_o     (done_o),
        .illegal_o  (illegal_o)
    );

    a_r7_reserved_never_passes: assert property (@(posedge clk) disable iff (rst)
        bad_code |-> !pass);

    a_r13_cond_held_while_busy: assert property (@(posedge clk) disable iff (rst)
        (exec_o || dec_o) |=> $stable(cond_q));

endmodule

// File: tb/cond_rep_seq_bench.sv
module cond_rep_seq_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [4:0]    cond;
    logic          rep;
    logic [4:0]    flags;
    logic [CW-1:0] cnt_reg;
    logic          exec_w, dec_w, done_w, ill_w;

    int n_checks = 0;
    int n_fail   = 0;
    int wd       = 0;

    always #10 clk = ~clk;

    cond_rep_seq #(.CNT_W(CW)) u_cond_rep_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .cond_i    (cond),
        .rep_i     (rep),
        .flags_i   (flags),
        .count_i   (cnt_reg),
        .exec_o    (exec_w),
        .dec_o     (dec_w),
        .done_o    (done_w),
        .illegal_o (ill_w)
    );

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pred(int code, bit [4:0] f, bit cz);
        bit cf, of, zf, sf, pf;
        cf = f[0]; of = f[1]; zf = f[2]; sf = f[3]; pf = f[4];
        case (code)
            0:  return 1'b1;
            1:  return cf;
            2:  return of;
            3:  return zf;
            4:  return sf;
            5:  return pf;
            6:  return !cf && !zf;
            7:  return !cf;
            8:  return cf;
            9:  return cf || zf;
            10: return !zf && (sf == of);
            11: return sf == of;
            12: return sf != of;
            13: return zf || (sf != of);
            14: return cz;
            default: return 1'b0;
        endcase
    endfunction

    // Runs one sequence and checks counts, timing and final state.
    task automatic run_case(string req, bit [4:0] c, bit r, int cnt, bit [4:0] f,
                            int flip_after, bit [4:0] flip_mask, bit hold_start,
                            int exp_exec, bit exp_ill);
        int cyc = 1, n_exec = 0, n_dec = 0, first = -1, done_at = -1, consec = 0;
        bit prev_exec = 0, ill_seen = 0;
        int exp_done;
        @(negedge clk);
        cnt_reg = CW'(cnt); flags = f; cond = c; rep = r; start = 1'b1;
        @(negedge clk);
        start = hold_start;
        while (done_at < 0 && cyc < 2000) begin
            @(negedge clk);
            cyc = cyc + 1;
            if (exec_w) begin
                n_exec = n_exec + 1;
                if (first < 0) first = cyc;
                if (n_exec == flip_after) flags = flags ^ flip_mask;
            end
            if (prev_exec && exec_w) consec = consec + 1;
            prev_exec = exec_w;
            if (dec_w) begin
                n_dec = n_dec + 1;
                cnt_reg = cnt_reg - 1'b1;
            end
            if (done_w) begin
                done_at = cyc;
                ill_seen = ill_w;
                start = 1'b0;
            end
        end
        exp_done = r ? (2 + 3 * exp_exec) : (exp_exec > 0 ? 3 : 2);
        check({req, " exec count"}, n_exec, exp_exec);
        check({req, " dec count (R8/R9)"}, n_dec, r ? exp_exec : 0);
        check({req, " illegal flag (R7)"}, int'(ill_seen), int'(exp_ill));
        check({req, " done cycle (R8/R9)"}, done_at, exp_done);
        check({req, " exec single-cycle R12"}, consec, 0);
        if (exp_exec > 0) check({req, " first exec cycle R8"}, first, 2);
        if (r) check({req, " final count R9"}, int'(cnt_reg), cnt - exp_exec);
        @(negedge clk);
        check({req, " done single pulse R12"}, int'(done_w), 0);
        check({req, " idle after done R13"}, int'(exec_w | dec_w | ill_w), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 exec after reset", int'(exec_w), 0);
        check("R1 dec after reset", int'(dec_w), 0);
        check("R1 done after reset", int'(done_w), 0);
        check("R1 illegal after reset", int'(ill_w), 0);
    endtask

    task automatic t_code_sweep();
        bit [4:0] pats [6] = '{5'b00000, 5'b11111, 5'b00101, 5'b01010, 5'b01000, 5'b10010};
        for (int code = 0; code < 15; code++) begin
            for (int p = 0; p < 6; p++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    string req;
                    int cnt;
                    bit res;
                    cnt = (p % 2 == 0) ? 0 : 3;
                    req = (code <= 5) ? "R2" : (code <= 9) ? "R3" : (code <= 13) ? "R4" : "R5";
                    if (inv == 1) req = {req, "+R6"};
                    res = pred(code, pats[p], cnt == 0) ^ inv[0];
                    run_case(req, {inv[0], 4'(code)}, 1'b0, cnt, pats[p], -1, 5'b0, 1'b0,
                             res ? 1 : 0, 1'b0);
                end
            end
        end
    endtask

    task automatic t_illegal();
        run_case("R7 reserved plain", 5'b01111, 1'b0, 3, 5'b11111, -1, 5'b0, 1'b0, 0, 1'b1);
        run_case("R7 reserved inverted", 5'b11111, 1'b0, 3, 5'b00000, -1, 5'b0, 1'b0, 0, 1'b1);
        run_case("R7 reserved repeat zero count", 5'b01111, 1'b1, 0, 5'b0, -1, 5'b0, 1'b0, 0, 1'b1);
    endtask

    task automatic t_repeat();
        run_case("R9 repeat three", 5'b00000, 1'b1, 3, 5'b0, -1, 5'b0, 1'b0, 3, 1'b0);
        run_case("R9 repeat one", 5'b00000, 1'b1, 1, 5'b0, -1, 5'b0, 1'b0, 1, 1'b0);
        run_case("R9 repeat long", 5'b00000, 1'b1, 200, 5'b0, -1, 5'b0, 1'b0, 200, 1'b0);
        run_case("R9+R6 inverted count-zero code", 5'b11110, 1'b1, 4, 5'b0, -1, 5'b0, 1'b0, 4, 1'b0);
    endtask

    task automatic t_zero_count();
        run_case("R10 repeat zero count", 5'b00000, 1'b1, 0, 5'b0, -1, 5'b0, 1'b0, 0, 1'b0);
        run_case("R10 repeat zero count carry true", 5'b00001, 1'b1, 0, 5'b00001, -1, 5'b0, 1'b0, 0, 1'b0);
    endtask

    task automatic t_retest();
        run_case("R11 zero flag set after second exec", 5'b10011, 1'b1, 5, 5'b00000, 2, 5'b00100, 1'b0, 2, 1'b0);
        run_case("R11 count-zero code false at entry", 5'b01110, 1'b1, 4, 5'b0, -1, 5'b0, 1'b0, 0, 1'b0);
        run_case("R11 carry cleared after first exec", 5'b00001, 1'b1, 6, 5'b00001, 1, 5'b00001, 1'b0, 1, 1'b0);
    endtask

    task automatic t_busy_start();
        run_case("R13 start held single", 5'b00000, 1'b0, 0, 5'b0, -1, 5'b0, 1'b1, 1, 1'b0);
        run_case("R13 start held repeat", 5'b00000, 1'b1, 2, 5'b0, -1, 5'b0, 1'b1, 2, 1'b0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; cond = '0; rep = 1'b0; flags = '0; cnt_reg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_code_sweep();
        t_illegal();
        t_repeat();
        t_zero_count();
        t_retest();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule